// File: doc/BRIEF.md
# Two-Wire Pulse Frame Receiver

This block takes the two data lines of a Wiegand-style access-control reader and turns the pulses on them into whole frames. A pulse on the zero line alone carries a 0 bit. A pulse on the one line alone carries a 1 bit. Both lines go through multi-flop synchronizers, and a bit is taken when the line pair moves into a single-line-active pattern, not on every clock it stays there.

No length field exists. The frame closes when a bit-period timer, armed at every new bit, runs out with both lines back at their inactive level. The frame is then reported with its bit count and its bits, the first bit received being the most significant. Illegal activity sends the receiver to an invalid state: both lines active together, or a line still active when the timer runs out. In the invalid state all line activity is ignored until both lines rest at the inactive level again. The active level and the bit period, from a fixed set of millisecond values scaled by the clock frequency, are set on configuration inputs.

Top module: `wgd_frame_rx`

## Requirements
- R1: A change of the synchronized line pair into the pattern "zero line active, one line inactive" produces exactly one `bit_stb` pulse with `bit_val`=0. The pattern "one line active, zero line inactive" produces one pulse with `bit_val`=1. Holding the pattern longer produces no further pulse.
- R2: With `act_high`=0 a line is active when low. With `act_high`=1 a line is active when high. The inactive level is always the opposite one.
- R3: Both lines active together while idle or receiving raises `rx_invalid` on the next cycle and discards the partial frame, so the next frame reports only its own bits.
- R4: The timer period P is TPM << s clock cycles. TPM = max(1, CLK_HZ/1000). s is `period_sel`, with codes 5, 6 and 7 all meaning 5, so codes 0..5 select 1, 2, 4, 8, 16 and 32 ms. `frame_stb` pulses exactly P cycles after the last `bit_stb` when both lines are inactive at that point.
- R5: At `frame_stb`, `frame_len` holds the number of bits stored. `frame_bits` holds them right-aligned: the first bit received sits at position `frame_len`-1, the last at position 0, and all higher positions are 0.
- R6: If the timer runs out while any line is active, no frame is reported and `rx_invalid` rises.
- R7: While `rx_invalid` is high, line activity produces no `bit_stb`. The flag clears one cycle after both lines become inactive.
- R8: At most MAX_BITS bits are stored. Further bits are dropped and set `frame_ovf`, which is reported with `frame_stb` together with `frame_len`=MAX_BITS and the first MAX_BITS bits.
- R9: After the synchronous reset, `bit_stb`, `frame_stb`, `rx_invalid`, `frame_len`, `frame_bits` and `frame_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| act_high | input | 1 | 1: lines active high, 0: lines active low |
| period_sel | input | 3 | Bit period code, 1 ms << code, clamped at code 5 |
| line_zero | input | 1 | Data line carrying 0 bits (asynchronous) |
| line_one | input | 1 | Data line carrying 1 bits (asynchronous) |
| bit_stb | output | 1 | One-cycle pulse per received bit |
| bit_val | output | 1 | Value of the bit flagged by bit_stb |
| frame_stb | output | 1 | One-cycle pulse when a frame closes |
| frame_len | output | $clog2(MAX_BITS+1) | Stored bit count of the last frame |
| frame_bits | output | MAX_BITS | Bits of the last frame, right-aligned |
| frame_ovf | output | 1 | Last frame had more than MAX_BITS bits |
| rx_invalid | output | 1 | Receiver is in the invalid state |

## Verification
The assertions check on every cycle how the synchronized line pattern steers the invalid flag. They check that it rises on a double-active change, holds until both lines go idle, and clears right after. They also check that no bit is flagged while invalid, that a frame closes only on an idle line pair, and that the reported length stays within bounds and equals MAX_BITS on overflow. Only the bench scenarios can show the exact timeout distance for every period code, the order and alignment of the frame bits for every length in both polarities, the discard of a partial frame, and a held line counting as a single bit.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_BAD  = 2'd2
  } rx_state_t;

  localparam logic [2:0] SEL_MAX = 3'd5;

  // Period codes above the largest legal value all map onto it.
  function automatic logic [2:0] sel_clamp(input logic [2:0] sel);
    return (sel > SEL_MAX) ? SEL_MAX : sel;
  endfunction

endpackage

// File: rtl/wgd_line_sync.sv
module wgd_line_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_high,
  input  logic [LANES-1:0] lines_i,
  output logic [LANES-1:0] act_o,
  output logic             chg_o
);

  logic [LANES-1:0] act_w;
  logic [LANES-1:0] prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= {STAGES{~act_high}};
      else     pipe_q <= {pipe_q[STAGES-2:0], lines_i[g]};
    end
    // A lane is active when its settled level equals the active level.
    assign act_w[g] = pipe_q[STAGES-1] ~^ act_high;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= act_w;
  end

  assign act_o = act_w;
  assign chg_o = (act_w != prev_q);

endmodule

// File: rtl/wgd_bit_timer.sv
module wgd_bit_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q   <= load_i - CNT_W'(1);
      armed_q <= 1'b1;
    end else if (stop_i) begin
      armed_q <= 1'b0;
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);

endmodule

// File: rtl/wgd_rx_fsm.sv
module wgd_rx_fsm
  import wgd_pkg::*;
#(
  parameter int MAX_BITS = 64,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          act_i,     // [0] zero line, [1] one line
  input  logic                chg_i,
  input  logic                expired_i,
  output logic                arm_o,
  output logic                stop_o,
  output logic                bit_stb_o,
  output logic                bit_val_o,
  output logic                frame_stb_o,
  output logic [LEN_W-1:0]    frame_len_o,
  output logic [MAX_BITS-1:0] frame_bits_o,
  output logic                frame_ovf_o,
  output logic                bad_o
);

  rx_state_t           state_q;
  logic [LEN_W-1:0]    cnt_q;
  logic [MAX_BITS-1:0] sh_q;
  logic                ovf_q;

  logic new_bit, both_act, bad_exit, timeout;

  always_comb begin
    new_bit  = chg_i && (state_q != RX_BAD) && (act_i == 2'b01 || act_i == 2'b10);
    both_act = chg_i && (state_q != RX_BAD) && (act_i == 2'b11);
    bad_exit = chg_i && (state_q == RX_BAD) && (act_i == 2'b00);
    timeout  = !chg_i && expired_i;
    arm_o    = new_bit;
    stop_o   = both_act || timeout;
  end

  always_ff @(posedge clk) begin
    bit_stb_o   <= 1'b0;
    frame_stb_o <= 1'b0;
    if (rst) begin
      state_q      <= RX_IDLE;
      cnt_q        <= '0;
      sh_q         <= '0;
      ovf_q        <= 1'b0;
      bit_val_o    <= 1'b0;
      frame_len_o  <= '0;
      frame_bits_o <= '0;
      frame_ovf_o  <= 1'b0;
      bad_o        <= 1'b0;
    end else if (new_bit) begin
      state_q   <= RX_DATA;
      bit_stb_o <= 1'b1;
      bit_val_o <= act_i[1];
      if (cnt_q < LEN_W'(MAX_BITS)) begin
        sh_q  <= {sh_q[MAX_BITS-2:0], act_i[1]};
        cnt_q <= cnt_q + LEN_W'(1);
      end else begin
        ovf_q <= 1'b1;
      end
    end else if (both_act) begin
      state_q <= RX_BAD;
      bad_o   <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      ovf_q   <= 1'b0;
    end else if (bad_exit) begin
      state_q <= RX_IDLE;
      bad_o   <= 1'b0;
    end else if (timeout) begin
      cnt_q <= '0;
      sh_q  <= '0;
      ovf_q <= 1'b0;
      if (act_i == 2'b00) begin
        state_q      <= RX_IDLE;
        frame_stb_o  <= 1'b1;
        frame_len_o  <= cnt_q;
        frame_bits_o <= sh_q;
        frame_ovf_o  <= ovf_q;
      end else begin
        state_q <= RX_BAD;
        bad_o   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wgd_frame_rx.sv
module wgd_frame_rx
  import wgd_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int MAX_BITS    = 64,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                act_high,
  input  logic [2:0]          period_sel,
  input  logic                line_zero,
  input  logic                line_one,
  output logic                bit_stb,
  output logic                bit_val,
  output logic                frame_stb,
  output logic [LEN_W-1:0]    frame_len,
  output logic [MAX_BITS-1:0] frame_bits,
  output logic                frame_ovf,
  output logic                rx_invalid
);

  localparam int TPM   = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int CNT_W = $clog2(TPM * 32 + 1);
  localparam logic [CNT_W-1:0] TPM_V = CNT_W'(TPM);

  logic [1:0]       act_w;
  logic             chg_w;
  logic             arm_w, stop_w, expired_w;
  logic [CNT_W-1:0] load_w;

  assign load_w = TPM_V << sel_clamp(period_sel);

  wgd_line_sync #(.LANES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .act_high (act_high),
    .lines_i  ({line_one, line_zero}),
    .act_o    (act_w),
    .chg_o    (chg_w)
  );

  wgd_bit_timer #(.CNT_W(CNT_W)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (arm_w),
    .stop_i    (stop_w),
    .load_i    (load_w),
    .expired_o (expired_w)
  );

  wgd_rx_fsm #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .act_i        (act_w),
    .chg_i        (chg_w),
    .expired_i    (expired_w),
    .arm_o        (arm_w),
    .stop_o       (stop_w),
    .bit_stb_o    (bit_stb),
    .bit_val_o    (bit_val),
    .frame_stb_o  (frame_stb),
    .frame_len_o  (frame_len),
    .frame_bits_o (frame_bits),
    .frame_ovf_o  (frame_ovf),
    .bad_o        (rx_invalid)
  );

endmodule

// File: rtl/wgd_frame_rx_chk.sv
module wgd_frame_rx_chk #(
  parameter int MAX_BITS = 64,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       act,
  input logic             chg,
  input logic             bit_stb,
  input logic             frame_stb,
  input logic [LEN_W-1:0] frame_len,
  input logic             frame_ovf,
  input logic             rx_invalid
);

  a_r3_double_active: assert property (@(posedge clk) disable iff (rst)
    (chg && act == 2'b11) |=> rx_invalid);

  a_r7_hold_invalid: assert property (@(posedge clk) disable iff (rst)
    (rx_invalid && !(chg && act == 2'b00)) |=> rx_invalid);

  a_r7_leave_invalid: assert property (@(posedge clk) disable iff (rst)
    (rx_invalid && chg && act == 2'b00) |=> !rx_invalid);

  a_r7_no_bit_invalid: assert property (@(posedge clk) disable iff (rst)
    rx_invalid |-> !bit_stb);

  a_r1_bit_on_change: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> $past(chg));

  a_r6_frame_on_idle: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> ($past(act) == 2'b00 && !rx_invalid));

  a_r5_len_bounds: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> (frame_len != '0 && frame_len <= LEN_W'(MAX_BITS)));

  a_r8_ovf_full: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && frame_ovf) |-> frame_len == LEN_W'(MAX_BITS));

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bit_stb && !frame_stb && !rx_invalid));

endmodule

bind wgd_frame_rx wgd_frame_rx_chk #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .act        (act_w),
  .chg        (chg_w),
  .bit_stb    (bit_stb),
  .frame_stb  (frame_stb),
  .frame_len  (frame_len),
  .frame_ovf  (frame_ovf),
  .rx_invalid (rx_invalid)
);

// File: tb/wgd_frame_rx_tb.sv
module wgd_frame_rx_tb_top;

  localparam int CLK_HZ = 8000;   // 8 ticks per ms keeps periods short
  localparam int TPM    = 8;
  localparam int MAXB   = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        act_high = 1'b0;
  logic [2:0]  period_sel = 3'd0;
  logic        line_zero = 1'b1;
  logic        line_one = 1'b1;
  logic        bit_stb, bit_val, frame_stb, frame_ovf, rx_invalid;
  logic [6:0]  frame_len;
  logic [63:0] frame_bits;

  always #2 clk = ~clk;

  wgd_frame_rx #(.CLK_HZ(CLK_HZ), .MAX_BITS(MAXB)) dut_i (
    .clk(clk), .rst(rst), .act_high(act_high), .period_sel(period_sel),
    .line_zero(line_zero), .line_one(line_one),
    .bit_stb(bit_stb), .bit_val(bit_val), .frame_stb(frame_stb),
    .frame_len(frame_len), .frame_bits(frame_bits), .frame_ovf(frame_ovf),
    .rx_invalid(rx_invalid)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // Output monitor
  int          cyc = 0, nbits = 0, nframes = 0, last_bit_cyc = 0, frame_cyc = 0;
  logic [63:0] bit_stream = '0, f_bits = '0;
  int          f_len = 0;
  logic        f_ovf = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bit_stb) begin
      nbits        <= nbits + 1;
      bit_stream   <= {bit_stream[62:0], bit_val};
      last_bit_cyc <= cyc;
    end
    if (frame_stb) begin
      nframes   <= nframes + 1;
      f_len     <= int'(frame_len);
      f_bits    <= frame_bits;
      f_ovf     <= frame_ovf;
      frame_cyc <= cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic clear_mon();
    settle();
    nbits = 0; nframes = 0; bit_stream = '0;
  endtask

  task automatic drive(input bit z_act, input bit o_act);
    line_zero = z_act ? act_high : ~act_high;
    line_one  = o_act ? act_high : ~act_high;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int hold);
    drive(!b, b);
    wait_cyc(hold);
    drive(1'b0, 1'b0);
    wait_cyc(2);
  endtask

  function automatic int period_of(input int sel);
    return TPM << ((sel > 5) ? 5 : sel);
  endfunction

  // Sends len bits, MSB-first from pat (bit len-1 first), and checks the frame.
  task automatic run_frame(input int len, input logic [127:0] pat, input int sel, input string pol);
    int p;
    logic [63:0] exp_bits;
    int exp_len;
    period_sel = 3'(sel);
    p = period_of(sel);
    clear_mon();
    for (int i = len - 1; i >= 0; i--) send_bit(pat[i], 2);
    wait_cyc(p + 12);
    settle();
    exp_len  = (len > MAXB) ? MAXB : len;
    exp_bits = (len > MAXB) ? pat[len-1 -: 64] :
               ((len == 64) ? pat[63:0] : (pat[63:0] & ((64'd1 << len) - 1)));
    check(nframes == 1, {"R4 frame count ", pol}, 64'(nframes), 64'd1);
    check(nbits == len, {"R1 bit strobes ", pol}, 64'(nbits), 64'(len));
    check(f_len == exp_len, {"R5 frame_len ", pol}, 64'(f_len), 64'(exp_len));
    check(f_bits == exp_bits, {"R5 frame_bits ", pol}, f_bits, exp_bits);
    check(f_ovf == (len > MAXB), "R8 overflow flag", 64'(f_ovf), 64'(len > MAXB));
    check(frame_cyc - last_bit_cyc == p, "R4 timeout distance", 64'(frame_cyc - last_bit_cyc), 64'(p));
    if (len <= MAXB)
      check(bit_stream == exp_bits, "R1 bit values", bit_stream, exp_bits);
  endtask

  initial begin
    logic [127:0] pat;
    act_high = 1'b0;
    drive(1'b0, 1'b0);
    wait_cyc(5);
    rst = 1'b0;
    settle();
    // R9: reset state
    check(!bit_stb && !frame_stb && !rx_invalid, "R9 strobes after reset", 64'({bit_stb, frame_stb, rx_invalid}), 64'd0);
    check(frame_len == 0 && frame_bits == 0 && !frame_ovf, "R9 frame fields after reset", frame_bits, 64'd0);
    wait_cyc(4);

    // R2/R5: every length in both polarities
    for (int pol = 0; pol < 2; pol++) begin
      act_high = pol[0];
      drive(1'b0, 1'b0);
      wait_cyc(6);
      for (int len = 1; len <= MAXB; len++) begin
        pat = {64'd0, 64'h9E37_79B9_7F4A_7C15 * 64'(len + 3) ^ 64'(len * 977)};
        run_frame(len, pat, 0, pol[0] ? "R2 active-high" : "R2 active-low");
      end
    end
    act_high = 1'b0;
    drive(1'b0, 1'b0);
    wait_cyc(6);

    // R4: every period code, including clamped codes
    for (int sel = 0; sel < 8; sel++)
      run_frame(3, 128'b101, sel, "R4 period sweep");

    // R8: overflow
    pat = {64'h0000_0000_0000_002D, 64'hC3A5_0F1E_96D2_7B48};
    run_frame(70, pat, 0, "R8 overflow");

    // R1: a long hold counts once
    period_sel = 3'd2;
    clear_mon();
    send_bit(1'b1, 12);
    send_bit(1'b0, 12);
    wait_cyc(period_of(2) + 10);
    settle();
    check(nbits == 2, "R1 held line counts once", 64'(nbits), 64'd2);
    check(f_bits == 64'b10 && f_len == 2, "R1 held frame bits", f_bits, 64'b10);

    // R3/R7: both lines active, activity while invalid, recovery
    period_sel = 3'd0;
    clear_mon();
    send_bit(1'b1, 2);
    send_bit(1'b1, 2);
    drive(1'b1, 1'b1);
    wait_cyc(5);
    settle();
    check(rx_invalid == 1'b1, "R3 invalid after both active", 64'(rx_invalid), 64'd1);
    drive(1'b0, 1'b1);
    wait_cyc(5);
    settle();
    check(nbits == 2, "R7 no bit while invalid", 64'(nbits), 64'd2);
    check(rx_invalid == 1'b1, "R7 invalid holds on single line", 64'(rx_invalid), 64'd1);
    drive(1'b0, 1'b0);
    wait_cyc(5);
    settle();
    check(rx_invalid == 1'b0, "R7 invalid clears when idle", 64'(rx_invalid), 64'd0);
    wait_cyc(30);
    settle();
    check(nframes == 0, "R3 partial frame discarded", 64'(nframes), 64'd0);
    run_frame(3, 128'b011, 0, "R3 fresh frame after discard");

    // R6: timer expires while a line is still active
    clear_mon();
    drive(1'b1, 1'b0);
    wait_cyc(period_of(0) + 8);
    settle();
    check(rx_invalid == 1'b1, "R6 invalid on active timeout", 64'(rx_invalid), 64'd1);
    drive(1'b0, 1'b0);
    wait_cyc(30);
    settle();
    check(nframes == 0, "R6 no frame on active timeout", 64'(nframes), 64'd0);
    check(rx_invalid == 1'b0, "R7 recovery after timeout", 64'(rx_invalid), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule